// File: doc/BRIEF.md
# Rolling-Shutter Double-Sample Readout Sequencer

This block steps through the rows of a pixel matrix that keeps integrating charge at all times. While a row is selected, the block strobes the ADC once to capture signal plus pedestal on every column at the same time. It then pulses that row's clear line and strobes the ADC again to capture the pedestal alone. Each column's second sample is subtracted from its first. Only differences above a programmable threshold leave the block, as a stream of (row, column, value) hits.

Readout runs as a rolling shutter. After a start, row 0 is selected first. The row index wraps after the last row, and the sequencer keeps running until a stop request, which lets the current row finish. The delay before each sample and the clear pulse width are run-time cycle counts inside a fixed row period. If a row's hits cannot all drain through the hit buffer before the next row's results arrive, the ones left over are lost and an overflow flag is set for that row.

Top module: `rs_readout_seq`

## Requirements
- R1: `gate_sel` is always one-hot or all-zero. One row stays selected for exactly ROW_CYC cycles. Rows are visited in ascending order and wrap from ROWS-1 to 0.
- R2: With S = `settle_cyc` and C = `clr_cyc` latched at start, and t counting from 0 in the first cycle of a row: `adc_strobe` is high at t = S (first sample) and at t = 2S+C+1 (second sample). It is high in no other cycle.
- R3: `clear_sel` is high only for the currently selected row, and only for the C cycles t = S+1 to S+C, between the two samples.
- R4: A hit value is the first sample minus the second sample. It is computed as a signed number SW+1 bits wide, so the MSB of `hit_val` is the sign bit.
- R5: A column gives a hit only when its difference is strictly greater than `threshold`. Results equal to the threshold, zero or negative are dropped.
- R6: Hits leave in the order the rows were read, and in ascending column order within a row. While `hit_valid` is high and `hit_ready` is low, the hit stays valid and its fields stay unchanged.
- R7: A row's hits that are still waiting when the next row's results arrive are discarded, and bit r of `ovf_rows` is set for that row r. The bit is cleared when row r's results are next loaded. A hit that has entered the buffer is never lost.
- R8: `frame_start` is high for exactly the first cycle of row 0.
- R9: A `stop` pulse lets the current row run to its end, after which all rows are deselected. A later start begins again at row 0.
- R10: `cfg_bad` is high when C = 0 or 2S+C+2 > ROW_CYC. While it is high, `start` is ignored. A setting with exactly 2S+C+2 = ROW_CYC is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin readout at row 0 when idle and the setting is legal |
| stop | input | 1 | Request to end readout after the current row |
| settle_cyc | input | TW | Cycles to wait before each sample (S) |
| clr_cyc | input | TW | Clear pulse width in cycles (C) |
| threshold | input | SW | Zero-suppression threshold, unsigned |
| cfg_bad | output | 1 | Current S/C setting does not fit the row period |
| gate_sel | output | ROWS | One-hot row select |
| clear_sel | output | ROWS | One-hot row clear |
| adc_strobe | output | 1 | Capture request for all column samples |
| col_data | input | COLS*SW | Column samples, column c at bits c*SW upward |
| frame_start | output | 1 | First cycle of row 0 |
| hit_valid | output | 1 | Hit available |
| hit_ready | input | 1 | Consumer accepts the hit |
| hit_row | output | RW | Row of the hit |
| hit_col | output | CLW | Column of the hit |
| hit_val | output | SW+1 | Signed pedestal-corrected value |
| ovf_rows | output | ROWS | Per-row overflow flags |

## Verification
Two functions can fall in the same cycle. The scanner may be pushing the last buffered hit of one row, or stalling on a full buffer, in the very cycle the next row's differences are loaded over its mask. In that cycle the overflow flag of the old row must be set and the flag of the new row cleared. The bench provokes this by holding `hit_ready` low through a frame in which every column hits. It then judges the exact `ovf_rows` pattern and the exact list of hits that survive once `hit_ready` is released. A further frame checks that the flags clear as their rows are loaded again.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } sq_state_e;

   function automatic int safe_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rsq_timing.sv
module rsq_timing
   import rsq_pkg::*;
#(
   parameter int ROWS    = 64,
   parameter int ROW_CYC = 24,
   parameter int RW      = 6,
   parameter int TW      = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            stop,
   input  logic [TW-1:0]   settle_cyc,
   input  logic [TW-1:0]   clr_cyc,
   output logic            cfg_bad,
   output logic [ROWS-1:0] gate_o,
   output logic [ROWS-1:0] clr_o,
   output logic            adc_strobe,
   output logic            samp_first,
   output logic            samp_second,
   output logic [RW-1:0]   row_idx,
   output logic            frame_start
);
   localparam int            NW     = TW + 2;
   localparam logic [TW-1:0] T_LAST = TW'(ROW_CYC - 1);
   localparam logic [RW-1:0] R_LAST = RW'(ROWS - 1);

   sq_state_e       st_q;
   logic [RW-1:0]   row_q;
   logic [TW-1:0]   t_q, s_q, c_q;
   logic            stop_q;
   logic            running, in_clr, row_end;
   logic [NW-1:0]   need, t_ext, first_at, clr_end, second_at;
   logic [ROWS-1:0] row_hot;

   always_comb begin
      need      = {1'b0, settle_cyc, 1'b0} + NW'(clr_cyc) + NW'(2);
      cfg_bad   = (clr_cyc == '0) || (need > NW'(ROW_CYC));
      t_ext     = NW'(t_q);
      first_at  = NW'(s_q);
      clr_end   = NW'(s_q) + NW'(c_q);
      second_at = {1'b0, s_q, 1'b0} + NW'(c_q) + NW'(1);
   end

   assign running     = (st_q == SQ_RUN);
   assign in_clr      = running && (t_ext > first_at) && (t_ext <= clr_end);
   assign samp_first  = running && (t_ext == first_at);
   assign samp_second = running && (t_ext == second_at);
   assign adc_strobe  = samp_first | samp_second;
   assign row_end     = running && (t_q == T_LAST);
   assign frame_start = running && (row_q == '0) && (t_q == '0);
   assign row_idx     = row_q;

   for (genvar g = 0; g < ROWS; g++) begin : g_dec
      assign row_hot[g] = (row_q == RW'(g));
   end

   assign gate_o = running ? row_hot : '0;
   assign clr_o  = in_clr  ? row_hot : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         row_q  <= '0;
         t_q    <= '0;
         s_q    <= '0;
         c_q    <= '0;
         stop_q <= 1'b0;
      end else if (!running) begin
         stop_q <= 1'b0;
         if (start && !cfg_bad) begin
            st_q  <= SQ_RUN;
            row_q <= '0;
            t_q   <= '0;
            s_q   <= settle_cyc;
            c_q   <= clr_cyc;
         end
      end else begin
         if (stop) stop_q <= 1'b1;
         if (row_end) begin
            t_q <= '0;
            if (stop_q || stop) st_q <= SQ_IDLE;
            else                row_q <= (row_q == R_LAST) ? '0 : row_q + 1'b1;
         end else begin
            t_q <= t_q + 1'b1;
         end
      end
   end

   AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_o)); // R1
   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (row_end && !stop_q && !stop) |=>
         (row_q == (($past(row_q) == R_LAST) ? '0 : $past(row_q) + 1'b1))); // R1
   AST_NO_STROBE_IN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_o) |-> !adc_strobe); // R2
   AST_CLR_MATCH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_o) |-> (clr_o == gate_o)); // R3
   AST_FSTART_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> gate_o[0]); // R8
   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (row_end && stop_q) |=> (gate_o == '0)); // R9

endmodule

// File: rtl/rsq_diff.sv
module rsq_diff #(
   parameter int COLS = 128,
   parameter int SW   = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   samp_first,
   input  logic [COLS*SW-1:0]     col_data,
   input  logic [SW-1:0]          thr,
   output logic [COLS*(SW+1)-1:0] diff_flat,
   output logic [COLS-1:0]        hit_mask
);
   localparam int DW = SW + 1;

   for (genvar g = 0; g < COLS; g++) begin : g_col
      logic [SW-1:0]        s1_q;
      logic signed [DW-1:0] d;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          s1_q <= '0;
         else if (samp_first) s1_q <= col_data[g*SW +: SW];
      end

      assign d = $signed({1'b0, s1_q}) - $signed({1'b0, col_data[g*SW +: SW]});
      assign diff_flat[g*DW +: DW] = d;
      assign hit_mask[g] = (d > $signed({1'b0, thr}));
   end

endmodule

// File: rtl/rsq_scan.sv
module rsq_scan #(
   parameter int ROWS = 64,
   parameter int COLS = 128,
   parameter int SW   = 16,
   parameter int RW   = 6,
   parameter int CLW  = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [RW-1:0]          load_row,
   input  logic [COLS-1:0]        new_mask,
   input  logic [COLS*(SW+1)-1:0] new_diff,
   input  logic                   fifo_full,
   output logic                   push,
   output logic [RW-1:0]          push_row,
   output logic [CLW-1:0]         push_col,
   output logic [SW:0]            push_val,
   output logic [ROWS-1:0]        ovf_rows
);
   localparam int DW = SW + 1;

   logic [COLS-1:0]    mask_q, pick_hot;
   logic [COLS*DW-1:0] val_q;
   logic [RW-1:0]      row_q;
   logic [ROWS-1:0]    ovf_q;
   logic [CLW-1:0]     pick;
   logic               lost;

   always_comb begin
      pick = '0;
      for (int i = COLS - 1; i >= 0; i--) begin
         if (mask_q[i]) pick = CLW'(i);
      end
   end

   assign push     = (|mask_q) && !fifo_full;
   assign pick_hot = push ? ({{(COLS-1){1'b0}}, 1'b1} << pick) : '0;
   assign lost     = load && (|(mask_q & ~pick_hot));
   assign push_row = row_q;
   assign push_col = pick;
   assign push_val = val_q[pick*DW +: DW];
   assign ovf_rows = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         val_q  <= '0;
         row_q  <= '0;
         ovf_q  <= '0;
      end else if (load) begin
         mask_q          <= new_mask;
         val_q           <= new_diff;
         row_q           <= load_row;
         ovf_q[load_row] <= 1'b0;
         if (lost) ovf_q[row_q] <= 1'b1;
      end else if (push) begin
         mask_q <= mask_q & ~pick_hot;
      end
   end

   AST_SCAN_NO_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !load) |=> !mask_q[$past(pick)]); // R6

endmodule

// File: rtl/rsq_hitfifo.sv
module rsq_hitfifo
   import rsq_pkg::*;
#(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   output logic         valid,
   output logic [W-1:0] dout,
   input  logic         ready
);
   localparam int AW = safe_w(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nx, rd_nx;
   logic [AW:0]   cnt_q;
   logic          pop;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nx = wr_q + 1'b1;
      assign rd_nx = rd_q + 1'b1;
   end else begin : g_odd
      assign wr_nx = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_nx = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
   end

   assign full  = (cnt_q == (AW+1)'(DEPTH));
   assign valid = (cnt_q != '0);
   assign pop   = valid && ready;
   assign dout  = mem[rd_q];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push && !full) wr_q <= wr_nx;
         if (pop)           rd_q <= rd_nx;
         case ({push && !full, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(dout))); // R6
   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (AW+1)'(DEPTH)); // R7

endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq
   import rsq_pkg::*;
#(
   parameter int ROWS      = 64,
   parameter int COLS      = 128,
   parameter int SW        = 16,
   parameter int ROW_CYC   = 24,
   parameter int HIT_DEPTH = 16,
   parameter int RW        = safe_w(ROWS),
   parameter int CLW       = safe_w(COLS),
   parameter int TW        = $clog2(ROW_CYC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               stop,
   input  logic [TW-1:0]      settle_cyc,
   input  logic [TW-1:0]      clr_cyc,
   input  logic [SW-1:0]      threshold,
   output logic               cfg_bad,
   output logic [ROWS-1:0]    gate_sel,
   output logic [ROWS-1:0]    clear_sel,
   output logic               adc_strobe,
   input  logic [COLS*SW-1:0] col_data,
   output logic               frame_start,
   output logic               hit_valid,
   input  logic               hit_ready,
   output logic [RW-1:0]      hit_row,
   output logic [CLW-1:0]     hit_col,
   output logic [SW:0]        hit_val,
   output logic [ROWS-1:0]    ovf_rows
);
   localparam int DW = SW + 1;
   localparam int HW = RW + CLW + DW;

   if (ROWS < 2)                begin : g_bad_rows  $error("ROWS must be at least 2");        end
   if (COLS < 1)                begin : g_bad_cols  $error("COLS must be at least 1");        end
   if (SW < 2)                  begin : g_bad_sw    $error("SW must be at least 2");          end
   if (ROW_CYC < 3)             begin : g_bad_cyc   $error("ROW_CYC must be at least 3");     end
   if (HIT_DEPTH < 2)           begin : g_bad_depth $error("HIT_DEPTH must be at least 2");   end
   if ((1 << TW) <= ROW_CYC)    begin : g_bad_tw    $error("TW too narrow for ROW_CYC");      end
   if ((1 << RW) < ROWS)        begin : g_bad_rw    $error("RW too narrow for ROWS");         end
   if ((1 << CLW) < COLS)       begin : g_bad_clw   $error("CLW too narrow for COLS");        end

   logic               samp_first, samp_second;
   logic [RW-1:0]      row_idx;
   logic [COLS*DW-1:0] diff_flat;
   logic [COLS-1:0]    hit_mask;
   logic               push, fifo_full;
   logic [RW-1:0]      push_row;
   logic [CLW-1:0]     push_col;
   logic [DW-1:0]      push_val;
   logic [HW-1:0]      fifo_out;

   rsq_timing #(.ROWS(ROWS), .ROW_CYC(ROW_CYC), .RW(RW), .TW(TW)) u_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .stop        (stop),
      .settle_cyc  (settle_cyc),
      .clr_cyc     (clr_cyc),
      .cfg_bad     (cfg_bad),
      .gate_o      (gate_sel),
      .clr_o       (clear_sel),
      .adc_strobe  (adc_strobe),
      .samp_first  (samp_first),
      .samp_second (samp_second),
      .row_idx     (row_idx),
      .frame_start (frame_start)
   );

   rsq_diff #(.COLS(COLS), .SW(SW)) u_diff (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_first (samp_first),
      .col_data   (col_data),
      .thr        (threshold),
      .diff_flat  (diff_flat),
      .hit_mask   (hit_mask)
   );

   rsq_scan #(.ROWS(ROWS), .COLS(COLS), .SW(SW), .RW(RW), .CLW(CLW)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (samp_second),
      .load_row  (row_idx),
      .new_mask  (hit_mask),
      .new_diff  (diff_flat),
      .fifo_full (fifo_full),
      .push      (push),
      .push_row  (push_row),
      .push_col  (push_col),
      .push_val  (push_val),
      .ovf_rows  (ovf_rows)
   );

   rsq_hitfifo #(.W(HW), .DEPTH(HIT_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({push_row, push_col, push_val}),
      .full  (fifo_full),
      .valid (hit_valid),
      .dout  (fifo_out),
      .ready (hit_ready)
   );

   assign {hit_row, hit_col, hit_val} = fifo_out;

   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_sel == '0) && cfg_bad) |=> (gate_sel == '0)); // R10

endmodule

// File: tb/rs_readout_seq_bench.sv
module rs_readout_seq_bench;
   localparam int ROWS = 4, COLS = 8, SW = 8, ROW_CYC = 16, HIT_DEPTH = 4;
   localparam int RW = 2, CLW = 3, TW = 5;

   logic               clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
   logic [TW-1:0]      settle_cyc = '0, clr_cyc = '0;
   logic [SW-1:0]      threshold = '0;
   logic               cfg_bad, adc_strobe, frame_start, hit_valid;
   logic               hit_ready = 1'b0;
   logic [ROWS-1:0]    gate_sel, clear_sel, ovf_rows;
   logic [COLS*SW-1:0] col_data;
   logic [RW-1:0]      hit_row;
   logic [CLW-1:0]     hit_col;
   logic [SW:0]        hit_val;

   always #4 clk = ~clk;

   rs_readout_seq #(.ROWS(ROWS), .COLS(COLS), .SW(SW), .ROW_CYC(ROW_CYC),
                    .HIT_DEPTH(HIT_DEPTH)) u_rs_readout_seq (.*);

   int n_tests = 0, n_fail = 0;
   int v1 [ROWS][COLS];
   int v2 [COLS];
   logic [ROWS-1:0] clr_gate = '0;
   int ms = 0, mc = 1, rdy_mode = 0, cyc = 0;

   // pixel model: signal+pedestal until the selected row has been cleared
   always_comb begin
      col_data = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (gate_sel[r]) begin
            for (int c = 0; c < COLS; c++)
               col_data[c*SW +: SW] = (clr_gate == gate_sel) ? SW'(v2[c]) : SW'(v1[r][c]);
         end
      end
   end

   function automatic int row_of(input logic [ROWS-1:0] g);
      int k = -1;
      for (int r = 0; r < ROWS; r++) if (g[r]) k = r;
      return k;
   endfunction

   // monitor, sampled at the falling edge
   int got_row [1024], got_col [1024], got_val [1024];
   int n_got = 0, t_in_row = 0, n_strobe = 0, n_clr = 0, n_fs = 0, n_rows = 0;
   int e_hot = 0, e_len = 0, e_ord = 0, e_tim = 0, e_clr = 0, e_fs = 0;
   logic [ROWS-1:0] prev_gate = '0;

   always @(negedge clk) begin
      cyc++;
      case (rdy_mode)
         0:       hit_ready = 1'b1;
         1:       hit_ready = cyc[0];
         default: hit_ready = 1'b0;
      endcase
      if (hit_valid && hit_ready && n_got < 1024) begin
         got_row[n_got] = int'(hit_row);
         got_col[n_got] = int'(hit_col);
         got_val[n_got] = int'($signed(hit_val));
         n_got++;
      end
      if (|clear_sel) clr_gate = clear_sel;
      if (gate_sel != prev_gate) begin
         if (prev_gate != '0 && t_in_row != ROW_CYC - 1) e_len++;
         if (prev_gate != '0 && gate_sel != '0 &&
             row_of(gate_sel) != (row_of(prev_gate) + 1) % ROWS) e_ord++;
         if (gate_sel != '0) n_rows++;
         t_in_row = 0;
      end else begin
         t_in_row++;
      end
      prev_gate = gate_sel;
      if (!$onehot0(gate_sel)) e_hot++;
      if (adc_strobe) begin
         n_strobe++;
         if (gate_sel == '0 || !(t_in_row == ms || t_in_row == 2*ms + mc + 1)) e_tim++;
      end
      if (|clear_sel) begin
         n_clr++;
         if (clear_sel != gate_sel) e_clr++;
         if (!(t_in_row > ms && t_in_row <= ms + mc)) e_tim++;
      end
      if (frame_start) begin
         n_fs++;
         if (!(gate_sel[0] && t_in_row == 0)) e_fs++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   int ex_row [1024], ex_col [1024], ex_val [1024];
   int n_exp = 0;

   task automatic add_frame(input int thr);
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            if (v1[r][c] - v2[c] > thr) begin
               ex_row[n_exp] = r; ex_col[n_exp] = c; ex_val[n_exp] = v1[r][c] - v2[c];
               n_exp++;
            end
   endtask

   task automatic cmp_hits(input int base, input string tag);
      chk(n_got - base == n_exp, {tag, " hit count"}, n_got - base, n_exp);
      for (int i = 0; i < n_exp && base + i < n_got; i++) begin
         chk(got_row[base+i] == ex_row[i], {tag, " row order"}, got_row[base+i], ex_row[i]);
         chk(got_col[base+i] == ex_col[i], {tag, " column order"}, got_col[base+i], ex_col[i]);
         chk(got_val[base+i] == ex_val[i], {tag, " value"}, got_val[base+i], ex_val[i]);
      end
   endtask

   task automatic run_frames(input int frames, input int s, input int c);
      int guard;
      ms = s; mc = c;
      settle_cyc = TW'(s); clr_cyc = TW'(c);
      clr_gate = '0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int f = 0; f < frames; f++) begin
         guard = 0;
         while (!gate_sel[ROWS-1] && guard < 500) begin @(negedge clk); guard++; end
         if (f < frames - 1)
            while (gate_sel[ROWS-1]) @(negedge clk);
      end
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      guard = 0;
      while (gate_sel != '0 && guard < 100) begin @(negedge clk); guard++; end
      repeat (40) @(negedge clk);
   endtask

   task automatic set_pattern(input int mode);
      for (int c = 0; c < COLS; c++) v2[c] = 20 + c;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            v1[r][c] = (mode == 0) ? v2[c] + ((r*3 + c*5) % 24) - 6 : v2[c] + 5;
      if (mode == 0) begin
         v1[1][2] = v2[2] + 10;
         v1[1][3] = v2[3] + 11;
         v1[2][6] = v2[6] - 9;
      end
   endtask

   task automatic t_reset;
      chk(gate_sel == '0, "R1 gate idle after reset", int'(gate_sel), 0);
      chk(clear_sel == '0, "R3 clear idle after reset", int'(clear_sel), 0);
      chk(!adc_strobe && !frame_start, "R2 no strobe after reset", int'(adc_strobe), 0);
      chk(!hit_valid && ovf_rows == '0, "R7 no hits/overflow after reset", int'(ovf_rows), 0);
   endtask

   task automatic t_cfg;
      int s0 = n_strobe;
      settle_cyc = 7; clr_cyc = 3; @(negedge clk);
      chk(cfg_bad, "R10 2S+C+2=19 rejected", int'(cfg_bad), 1);
      settle_cyc = 0; clr_cyc = 0; @(negedge clk);
      chk(cfg_bad, "R10 zero clear rejected", int'(cfg_bad), 1);
      settle_cyc = 7; clr_cyc = 3;
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (30) @(negedge clk);
      chk(gate_sel == '0 && n_strobe == s0, "R10 start ignored when bad", n_strobe - s0, 0);
      settle_cyc = 6; clr_cyc = 2; @(negedge clk);
      chk(!cfg_bad, "R10 exact fit accepted", int'(cfg_bad), 0);
   endtask

   task automatic t_basic;
      int b = n_got, st = n_strobe, cl = n_clr, fs = n_fs, nr = n_rows;
      set_pattern(0); threshold = 10; rdy_mode = 1;
      run_frames(1, 1, 2);
      n_exp = 0; add_frame(10);
      cmp_hits(b, "R4 R5 R6 basic");
      chk(n_strobe - st == 2*ROWS, "R2 two strobes per row", n_strobe - st, 2*ROWS);
      chk(n_clr - cl == 2*ROWS, "R3 clear width C per row", n_clr - cl, 2*ROWS);
      chk(n_fs - fs == 1, "R8 one frame start", n_fs - fs, 1);
      chk(n_rows - nr == ROWS, "R9 stop ends after current row", n_rows - nr, ROWS);
      chk(gate_sel == '0, "R9 idle after stop", int'(gate_sel), 0);
   endtask

   task automatic t_wrap;
      int b = n_got, fs = n_fs, nr = n_rows;
      set_pattern(0); threshold = 0; rdy_mode = 0;
      run_frames(2, 6, 2);
      n_exp = 0; add_frame(0); add_frame(0);
      cmp_hits(b, "R1 R6 wrap two frames");
      chk(n_fs - fs == 2, "R8 frame start per frame", n_fs - fs, 2);
      chk(n_rows - nr == 2*ROWS, "R1 rows wrap", n_rows - nr, 2*ROWS);
      chk(ovf_rows == '0, "R7 no overflow when drained", int'(ovf_rows), 0);
   endtask

   task automatic t_ovf;
      int b;
      set_pattern(1); threshold = 0; rdy_mode = 2;
      b = n_got;
      run_frames(1, 1, 1);
      chk(ovf_rows == 4'b0111, "R7 overflow rows 0..2", int'(ovf_rows), 7);
      chk(n_got == b, "R6 nothing taken while not ready", n_got - b, 0);
      rdy_mode = 0;
      repeat (30) @(negedge clk);
      n_exp = 0;
      for (int c = 0; c < 4; c++) begin
         ex_row[n_exp] = 0; ex_col[n_exp] = c; ex_val[n_exp] = 5; n_exp++;
      end
      for (int c = 0; c < COLS; c++) begin
         ex_row[n_exp] = 3; ex_col[n_exp] = c; ex_val[n_exp] = 5; n_exp++;
      end
      cmp_hits(b, "R7 survivors");
      threshold = 200;
      run_frames(1, 1, 1);
      chk(ovf_rows == '0, "R7 flags cleared on reload", int'(ovf_rows), 0);
   endtask

   task automatic t_timing;
      chk(e_hot == 0, "R1 gate one-hot", e_hot, 0);
      chk(e_len == 0, "R1 row length", e_len, 0);
      chk(e_ord == 0, "R1 row order", e_ord, 0);
      chk(e_tim == 0, "R2 strobe/clear timing", e_tim, 0);
      chk(e_clr == 0, "R3 clear on selected row", e_clr, 0);
      chk(e_fs == 0, "R8 frame start placement", e_fs, 0);
   endtask

   initial begin
      set_pattern(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg();
      t_basic();
      t_wrap();
      t_ovf();
      t_timing();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule